// File: doc/BRIEF.md
# Two-Level Virtual Register Renamer

This block is the rename stage of an out-of-order core whose architected register file is larger than its physical value store. Each logical register is mapped to a virtual register number through a direct-mapped alias table. A virtual number holds no storage. Its low bits select a slot in a small direct-indexed physical file, and its upper bits act as a check tag. There are more virtual numbers than logical registers, so renaming cannot deadlock.

A destination can be renamed only to a virtual number that meets two conditions at once: the number is free in the virtual free list, and the physical slot given by its low bits is free in the slot vector. Candidates are scanned from one past the previous allocation, so freshly committed values stay resident in their slots as long as possible.

A slot is claimed at rename and released when the owning instruction commits. The old slot contents are left in place until writeback, which is outside this block. A virtual number returns to the free list when a later writer of the same logical register commits. A flush discards every uncommitted mapping and restores the committed view.

Top module: `vreg_renamer`

## Requirements
- R1: After reset, logical register i maps to virtual number i. Virtual numbers at or above the logical register count are free, and all physical slots are free.
- R2: Source operands read the alias table before the same cycle's destination update, so an instruction that reads its own destination sees the prior mapping.
- R3: An allocated virtual number v is free in the virtual list, and slot v mod NUM_PHYS (the low bits of v) is free. Among those candidates, the first found scanning upward from one past the previous allocation (wrapping) is chosen. The scan starts at 0 after reset.
- R4: A fired rename writes the new number into the alias table for its destination. It reports the number it replaced on `ren_old_vrn` and marks the slot busy.
- R5: `ren_stall` is high when `ren_valid` and `ren_has_dst` are set and no candidate exists. A stalled rename changes no mapping, free bit or scan position.
- R6: A commit frees the slot of `commit_vrn` from the next cycle. It also frees the virtual number that the committed logical register held in the committed view, and makes `commit_vrn` the committed mapping.
- R7: The number of busy slots always equals the number of renamed but uncommitted instructions, so in-flight work is bounded by NUM_PHYS.
- R8: A flush restores every alias entry to the committed view, including a commit in the same cycle. It frees all uncommitted virtual numbers and all slots, ignores any rename in that cycle, and leaves the scan position unchanged.
- R9: A rename without a destination allocates nothing and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | Rename request present |
| ren_has_dst | input | 1 | Request writes a destination |
| ren_dst | input | clog2(NUM_LOGICAL) | Destination logical register |
| ren_src0 | input | clog2(NUM_LOGICAL) | First source logical register |
| ren_src1 | input | clog2(NUM_LOGICAL) | Second source logical register |
| commit_valid | input | 1 | Oldest in-flight writer commits |
| commit_ldst | input | clog2(NUM_LOGICAL) | Logical destination of the committing instruction |
| commit_vrn | input | clog2(NUM_VIRTUAL) | Virtual number of the committing instruction |
| flush | input | 1 | Discard all uncommitted renames |
| ren_src0_vrn | output | clog2(NUM_VIRTUAL) | Mapping of the first source |
| ren_src1_vrn | output | clog2(NUM_VIRTUAL) | Mapping of the second source |
| ren_dst_vrn | output | clog2(NUM_VIRTUAL) | Virtual number chosen for the destination |
| ren_old_vrn | output | clog2(NUM_VIRTUAL) | Mapping replaced by the destination |
| ren_stall | output | 1 | Rename cannot proceed this cycle |

## Verification
The assertions check several properties on every cycle:
- each allocation is free in both lists;
- claimed slots become busy and committed slots become free;
- released virtual numbers return to the free list;
- a stall freezes both free lists;
- a flush frees all slots;
- the count of busy slots always equals the count of uncommitted virtual numbers.

Only the bench scenarios show the values that appear at the ports. These include the prior-mapping view for self-referencing sources, the exact wrap-around scan order, and the mappings that survive a flush coinciding with a commit. A reference model driven by long pseudo-random traffic covers these values, including stalls caused by a free slot whose eligible virtual numbers are all taken.

// File: rtl/vrn_pkg.sv
package vrn_pkg;
  localparam int DEF_LOGICAL = 256;
  localparam int DEF_VIRTUAL = 512;
  localparam int DEF_PHYS    = 64;

  // next position of a wrapping index
  function automatic int unsigned wrap_next(int unsigned v, int unsigned n);
    return (v + 1) % n;
  endfunction
endpackage

// File: rtl/vrn_alias_map.sv
module vrn_alias_map #(
  parameter int NL = 256,
  parameter int VW = 9,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] rd0_idx,
  input  logic [LW-1:0] rd1_idx,
  input  logic [LW-1:0] rd2_idx,
  output logic [VW-1:0] rd0_val,
  output logic [VW-1:0] rd1_val,
  output logic [VW-1:0] rd2_val,
  input  logic          wr_en,
  input  logic [LW-1:0] wr_idx,
  input  logic [VW-1:0] wr_val,
  input  logic          cm_en,
  input  logic [LW-1:0] cm_idx,
  input  logic [VW-1:0] cm_val,
  input  logic          flush,
  output logic [VW-1:0] arch_old
);
  logic [VW-1:0] spec_q [NL];
  logic [VW-1:0] arch_q [NL];
  logic [VW-1:0] arch_d [NL];

  always_comb begin
    arch_d = arch_q;
    if (cm_en) arch_d[cm_idx] = cm_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NL; i++) begin
        spec_q[i] <= VW'(i);
        arch_q[i] <= VW'(i);
      end
    end else begin
      arch_q <= arch_d;
      if (flush)      spec_q <= arch_d;
      else if (wr_en) spec_q[wr_idx] <= wr_val;
    end
  end

  // reads see the table before this cycle's write
  assign rd0_val  = spec_q[rd0_idx];
  assign rd1_val  = spec_q[rd1_idx];
  assign rd2_val  = spec_q[rd2_idx];
  assign arch_old = arch_q[cm_idx];

  // R4: a fired rename is visible in the table next cycle
  a_r4_map_written: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !flush) |=> (spec_q[$past(wr_idx)] == $past(wr_val)));
  // R8: flush makes the speculative entry match the committed entry
  a_r8_flush_restores: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (spec_q[$past(rd0_idx)] == arch_q[$past(rd0_idx)]));
endmodule

// File: rtl/vrn_free_list.sv
module vrn_free_list #(
  parameter int NL = 256,
  parameter int NV = 512,
  parameter int VW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_en,
  input  logic [VW-1:0] alloc_vrn,
  input  logic          rel_en,
  input  logic [VW-1:0] rel_vrn,
  input  logic          cm_en,
  input  logic [VW-1:0] cm_vrn,
  input  logic          flush,
  output logic [NV-1:0] free_o,
  output logic [NV-1:0] spec_o
);
  logic [NV-1:0] free_q, free_d, spec_q, spec_d;

  function automatic logic [NV-1:0] reset_free();
    logic [NV-1:0] m;
    for (int i = 0; i < NV; i++) m[i] = (i >= NL);
    return m;
  endfunction

  always_comb begin
    free_d = free_q;
    spec_d = spec_q;
    if (alloc_en) begin
      free_d[alloc_vrn] = 1'b0;
      spec_d[alloc_vrn] = 1'b1;
    end
    if (cm_en)  spec_d[cm_vrn]  = 1'b0;
    if (rel_en) free_d[rel_vrn] = 1'b1;
    if (flush) begin
      free_d = free_d | spec_d;
      spec_d = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      free_q <= reset_free();
      spec_q <= '0;
    end else begin
      free_q <= free_d;
      spec_q <= spec_d;
    end
  end

  assign free_o = free_q;
  assign spec_o = spec_q;

  // R6: superseded number is back in the pool next cycle
  a_r6_vrn_released: assert property (@(posedge clk) disable iff (!rst_n)
    rel_en |=> free_q[$past(rel_vrn)]);
  // R6: committing instruction owns an uncommitted number
  a_r6_commit_is_spec: assert property (@(posedge clk) disable iff (!rst_n)
    cm_en |-> spec_q[cm_vrn]);
endmodule

// File: rtl/vrn_slot_vector.sv
module vrn_slot_vector #(
  parameter int NP = 64,
  parameter int PW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_en,
  input  logic [PW-1:0] alloc_slot,
  input  logic          cm_en,
  input  logic [PW-1:0] cm_slot,
  input  logic          flush,
  output logic [NP-1:0] free_o
);
  logic [NP-1:0] free_q, free_d;

  always_comb begin
    free_d = free_q;
    if (alloc_en) free_d[alloc_slot] = 1'b0;
    if (cm_en)    free_d[cm_slot]    = 1'b1;
    if (flush)    free_d             = '1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) free_q <= '1;
    else        free_q <= free_d;
  end

  assign free_o = free_q;

  // R4: a claimed slot is busy next cycle
  a_r4_slot_claimed: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_en && !flush) |=> !free_q[$past(alloc_slot)]);
  // R6: commit releases the slot it held
  a_r6_slot_released: assert property (@(posedge clk) disable iff (!rst_n)
    cm_en |=> free_q[$past(cm_slot)]);
  a_r6_commit_slot_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cm_en |-> !free_q[cm_slot]);
  // R8: flush empties the machine
  a_r8_flush_all_free: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (&free_q));
endmodule

// File: rtl/vrn_picker.sv
module vrn_picker #(
  parameter int NV = 512,
  parameter int NP = 64,
  parameter int VW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NV-1:0] vfree,
  input  logic [NP-1:0] pfree,
  input  logic          advance,
  output logic          found,
  output logic [VW-1:0] pick
);
  logic [NV-1:0] cand;
  logic [VW-1:0] ptr_q;
  logic [VW:0]   scan_res;

  // a number qualifies only if it and its slot are both free
  for (genvar g = 0; g < NV; g++) begin : g_cand
    assign cand[g] = vfree[g] & pfree[g % NP];
  end

  // first set bit at or after start, wrapping; MSB flags a hit
  function automatic logic [VW:0] scan_from(input logic [NV-1:0] m,
                                            input logic [VW-1:0] start);
    logic [VW:0]   r;
    logic [VW-1:0] idx;
    r = '0;
    for (int i = NV - 1; i >= 0; i--) begin
      idx = start + VW'(i);
      if (m[idx]) r = {1'b1, idx};
    end
    return r;
  endfunction

  assign scan_res = scan_from(cand, ptr_q);
  assign found    = scan_res[VW];
  assign pick     = scan_res[VW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)       ptr_q <= '0;
    else if (advance) ptr_q <= VW'(vrn_pkg::wrap_next(32'(pick), NV));
  end

  // R3: an advance only happens on a real candidate
  a_r3_advance_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    advance |-> found);
endmodule

// File: rtl/vreg_renamer.sv
module vreg_renamer #(
  parameter int NUM_LOGICAL = vrn_pkg::DEF_LOGICAL,
  parameter int NUM_VIRTUAL = vrn_pkg::DEF_VIRTUAL,
  parameter int NUM_PHYS    = vrn_pkg::DEF_PHYS
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           ren_valid,
  input  logic                           ren_has_dst,
  input  logic [$clog2(NUM_LOGICAL)-1:0] ren_dst,
  input  logic [$clog2(NUM_LOGICAL)-1:0] ren_src0,
  input  logic [$clog2(NUM_LOGICAL)-1:0] ren_src1,
  input  logic                           commit_valid,
  input  logic [$clog2(NUM_LOGICAL)-1:0] commit_ldst,
  input  logic [$clog2(NUM_VIRTUAL)-1:0] commit_vrn,
  input  logic                           flush,
  output logic [$clog2(NUM_VIRTUAL)-1:0] ren_src0_vrn,
  output logic [$clog2(NUM_VIRTUAL)-1:0] ren_src1_vrn,
  output logic [$clog2(NUM_VIRTUAL)-1:0] ren_dst_vrn,
  output logic [$clog2(NUM_VIRTUAL)-1:0] ren_old_vrn,
  output logic                           ren_stall
);
  localparam int LW = $clog2(NUM_LOGICAL);
  localparam int VW = $clog2(NUM_VIRTUAL);
  localparam int PW = $clog2(NUM_PHYS);

  // named events for the assertions
  logic          alloc_fire;
  logic          commit_fire;
  logic          found;
  logic [VW-1:0] pick_vrn;
  logic [VW-1:0] arch_old;
  logic [NUM_VIRTUAL-1:0] vfree, vspec;
  logic [NUM_PHYS-1:0]    pfree;

  assign alloc_fire  = ren_valid && ren_has_dst && found && !flush;
  assign commit_fire = commit_valid;
  assign ren_stall   = ren_valid && ren_has_dst && !found;
  assign ren_dst_vrn = pick_vrn;

  vrn_alias_map #(.NL(NUM_LOGICAL), .VW(VW), .LW(LW)) u_map (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd0_idx  (ren_src0),
    .rd1_idx  (ren_src1),
    .rd2_idx  (ren_dst),
    .rd0_val  (ren_src0_vrn),
    .rd1_val  (ren_src1_vrn),
    .rd2_val  (ren_old_vrn),
    .wr_en    (alloc_fire),
    .wr_idx   (ren_dst),
    .wr_val   (pick_vrn),
    .cm_en    (commit_fire),
    .cm_idx   (commit_ldst),
    .cm_val   (commit_vrn),
    .flush    (flush),
    .arch_old (arch_old)
  );

  vrn_free_list #(.NL(NUM_LOGICAL), .NV(NUM_VIRTUAL), .VW(VW)) u_vfree (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_en  (alloc_fire),
    .alloc_vrn (pick_vrn),
    .rel_en    (commit_fire),
    .rel_vrn   (arch_old),
    .cm_en     (commit_fire),
    .cm_vrn    (commit_vrn),
    .flush     (flush),
    .free_o    (vfree),
    .spec_o    (vspec)
  );

  vrn_slot_vector #(.NP(NUM_PHYS), .PW(PW)) u_pfree (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_en   (alloc_fire),
    .alloc_slot (pick_vrn[PW-1:0]),
    .cm_en      (commit_fire),
    .cm_slot    (commit_vrn[PW-1:0]),
    .flush      (flush),
    .free_o     (pfree)
  );

  vrn_picker #(.NV(NUM_VIRTUAL), .NP(NUM_PHYS), .VW(VW)) u_pick (
    .clk     (clk),
    .rst_n   (rst_n),
    .vfree   (vfree),
    .pfree   (pfree),
    .advance (alloc_fire),
    .found   (found),
    .pick    (pick_vrn)
  );

  // R3: both lists agree the chosen number is usable
  a_r3_pick_both_free: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |-> (vfree[pick_vrn] && pfree[pick_vrn[PW-1:0]]));
  // R7: busy slots track uncommitted numbers one for one
  a_r7_inflight_match: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(vspec) + $countones(pfree)) == NUM_PHYS);
  // R5: a lone stall leaves both lists untouched
  a_r5_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_stall && !commit_fire && !flush) |=> ($stable(vfree) && $stable(pfree)));
endmodule

// File: tb/vreg_renamer_tb.sv
module vreg_renamer_tb;
  localparam int NL = 8, NV = 16, NP = 4;
  localparam int LW = 3, VW = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;  // 10 ns period

  logic rst_n, ren_valid, ren_has_dst, commit_valid, flush, ren_stall;
  logic [LW-1:0] ren_dst, ren_src0, ren_src1, commit_ldst;
  logic [VW-1:0] commit_vrn, ren_src0_vrn, ren_src1_vrn, ren_dst_vrn, ren_old_vrn;

  vreg_renamer #(.NUM_LOGICAL(NL), .NUM_VIRTUAL(NV), .NUM_PHYS(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_has_dst(ren_has_dst),
    .ren_dst(ren_dst), .ren_src0(ren_src0), .ren_src1(ren_src1),
    .commit_valid(commit_valid), .commit_ldst(commit_ldst), .commit_vrn(commit_vrn),
    .flush(flush), .ren_src0_vrn(ren_src0_vrn), .ren_src1_vrn(ren_src1_vrn),
    .ren_dst_vrn(ren_dst_vrn), .ren_old_vrn(ren_old_vrn), .ren_stall(ren_stall));

  int checks = 0, fails = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // applied at the falling edge; takes effect at the next rising edge
  task automatic drive(bit v, bit hd, int d, int s0, int s1, bit cv, int cl, int cvr, bit fl);
    @(negedge clk);
    ren_valid = v; ren_has_dst = hd; ren_dst = LW'(d);
    ren_src0 = LW'(s0); ren_src1 = LW'(s1);
    commit_valid = cv; commit_ldst = LW'(cl); commit_vrn = VW'(cvr); flush = fl;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ren_valid = 0; ren_has_dst = 0; commit_valid = 0; flush = 0;
    ren_dst = '0; ren_src0 = '0; ren_src1 = '0; commit_ldst = '0; commit_vrn = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // {has_dst, dst, src0, src1, exp_src0, exp_src1, exp_dst, exp_old, exp_stall}
  localparam logic [26:0] TAB [7] = '{
    {1'b1, 3'd5, 3'd5, 3'd7, 4'd5, 4'd7,  4'd8,  4'd5, 1'b0},  // self-read
    {1'b1, 3'd7, 3'd5, 3'd7, 4'd8, 4'd7,  4'd9,  4'd7, 1'b0},
    {1'b0, 3'd0, 3'd5, 3'd7, 4'd8, 4'd9,  4'd0,  4'd0, 1'b0},  // no dst
    {1'b1, 3'd5, 3'd5, 3'd2, 4'd8, 4'd2,  4'd10, 4'd8, 1'b0},
    {1'b1, 3'd2, 3'd2, 3'd7, 4'd2, 4'd9,  4'd11, 4'd2, 1'b0},
    {1'b1, 3'd3, 3'd3, 3'd5, 4'd3, 4'd10, 4'd0,  4'd0, 1'b1},  // slots full
    {1'b0, 3'd0, 3'd3, 3'd2, 4'd3, 4'd11, 4'd0,  4'd0, 1'b0}
  };

  // reference model state
  int m_alias[NL], m_arch[NL];
  bit m_vfree[NV], m_spec[NV], m_pfree[NP];
  int m_ptr;
  int q_l[64], q_v[64];
  int qh, qt, qn;

  task automatic model_reset();
    for (int i = 0; i < NL; i++) begin m_alias[i] = i; m_arch[i] = i; end
    for (int i = 0; i < NV; i++) begin m_vfree[i] = (i >= NL); m_spec[i] = 0; end
    for (int i = 0; i < NP; i++) m_pfree[i] = 1;
    m_ptr = 0; qh = 0; qt = 0; qn = 0;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    // R1: identity map, first free number is NL in slot 0
    drive(0, 0, 0, 3, 7, 0, 0, 0, 0);
    chk("R1", "src0 after reset", int'(ren_src0_vrn), 3);
    chk("R1", "src1 after reset", int'(ren_src1_vrn), 7);
    chk("R1", "first candidate", int'(ren_dst_vrn), NL);
    chk("R1", "no stall", int'(ren_stall), 0);

    // vector table: R2 R3 R4 R5 R9
    for (int r = 0; r < 7; r++) begin
      logic [26:0] e;
      e = TAB[r];
      drive(1, e[26], int'(e[25:23]), int'(e[22:20]), int'(e[19:17]), 0, 0, 0, 0);
      chk("R2", $sformatf("row%0d src0", r), int'(ren_src0_vrn), int'(e[16:13]));
      chk("R2", $sformatf("row%0d src1", r), int'(ren_src1_vrn), int'(e[12:9]));
      chk("R5", $sformatf("row%0d stall", r), int'(ren_stall), int'(e[0]));
      if (e[26] && !e[0]) begin
        chk("R3", $sformatf("row%0d dst", r), int'(ren_dst_vrn), int'(e[8:5]));
        chk("R4", $sformatf("row%0d old", r), int'(ren_old_vrn), int'(e[4:1]));
      end
    end

    // R6: commit of number 8 frees slot 0; next pick scans from 12
    drive(0, 0, 0, 0, 0, 1, 5, 8, 0);
    drive(1, 1, 3, 5, 7, 0, 0, 0, 0);
    chk("R6", "stall cleared by commit", int'(ren_stall), 0);
    chk("R6", "dst after slot release", int'(ren_dst_vrn), 12);
    chk("R4", "old of reg3", int'(ren_old_vrn), 3);
    chk("R2", "src0 speculative map", int'(ren_src0_vrn), 10);
    // commit number 9 frees slot 1, then flush with a rename that could fire
    drive(0, 0, 0, 0, 0, 1, 7, 9, 0);
    drive(1, 1, 4, 0, 0, 0, 0, 0, 1);
    chk("R8", "rename candidate present in flush cycle", int'(ren_stall), 0);
    drive(1, 0, 0, 4, 7, 0, 0, 0, 0);
    chk("R8", "rename in flush cycle ignored", int'(ren_src0_vrn), 4);
    chk("R8", "committed map kept", int'(ren_src1_vrn), 9);
    chk("R8", "scan position kept", int'(ren_dst_vrn), 13);
    drive(1, 0, 0, 5, 2, 0, 0, 0, 0);
    chk("R8", "reg5 committed map", int'(ren_src0_vrn), 8);
    chk("R8", "reg2 speculative map dropped", int'(ren_src1_vrn), 2);
    chk("R9", "no-dst rename never stalls", int'(ren_stall), 0);

    // model-driven traffic: R3 R4 R5 R6 R7 R8
    do_reset();
    model_reset();
    for (int cyc = 0; cyc < 6000; cyc++) begin
      bit v, hd, cv, fl, fnd, fire;
      int d, s0, s1, cl, cvr, pv;
      v  = ($urandom % 4) != 0;
      hd = ($urandom % 4) != 0;
      d  = $urandom % NL; s0 = $urandom % NL; s1 = $urandom % NL;
      cv = (qn > 0) && (($urandom % 3) == 0);
      cl = cv ? q_l[qh] : 0;
      cvr = cv ? q_v[qh] : 0;
      fl = ($urandom % 97) == 0;
      drive(v, hd, d, s0, s1, cv, cl, cvr, fl);
      fnd = 0; pv = 0;
      for (int i = NV - 1; i >= 0; i--) begin
        int c;
        c = (m_ptr + i) % NV;
        if (m_vfree[c] && m_pfree[c % NP]) begin fnd = 1; pv = c; end
      end
      chk("R2", "model src0", int'(ren_src0_vrn), m_alias[s0]);
      chk("R2", "model src1", int'(ren_src1_vrn), m_alias[s1]);
      chk("R5", "model stall", int'(ren_stall), int'(v && hd && !fnd));
      fire = v && hd && fnd;
      if (fire) begin
        chk("R3", "model dst", int'(ren_dst_vrn), pv);
        chk("R4", "model old", int'(ren_old_vrn), m_alias[d]);
      end
      if (cv) begin
        m_pfree[cvr % NP] = 1;
        m_vfree[m_arch[cl]] = 1;
        m_spec[cvr] = 0;
        m_arch[cl] = cvr;
        qh = (qh + 1) % 64; qn--;
      end
      if (fl) begin
        for (int i = 0; i < NL; i++) m_alias[i] = m_arch[i];
        for (int i = 0; i < NV; i++) begin
          if (m_spec[i]) m_vfree[i] = 1;
          m_spec[i] = 0;
        end
        for (int i = 0; i < NP; i++) m_pfree[i] = 1;
        qh = 0; qt = 0; qn = 0;
      end else if (fire) begin
        m_alias[d] = pv; m_vfree[pv] = 0; m_spec[pv] = 1;
        m_pfree[pv % NP] = 0; m_ptr = (pv + 1) % NV;
        q_l[qt] = d; q_v[qt] = pv; qt = (qt + 1) % 64; qn++;
      end
      // R7: never more uncommitted writers than slots
      if (qn > NP) chk("R7", "in-flight bound", qn, NP);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule